// File: doc/BRIEF.md
# Two-Bit Tile Background Renderer

This block draws one background plane into a 256 x 224 frame of 15-bit colours. The plane is a grid of 32 x 28 tiles of 8 x 8 pixels each, and every pixel has two bits of colour. When it receives a start pulse, the renderer walks the frame in raster order. For each tile of the current line it reads a two-byte map entry from a 64 KiB byte-wide video memory and decodes the tile number and palette number from it. It then reads the two plane bytes of the tile line. Each pixel's two-bit colour is then looked up in a palette memory.

The video memory read port carries one byte per cycle. The fetches for the next tile overlap the eight output cycles of the current one, so after a short preload the block emits one pixel on every cycle, with its coordinates, and it pulses a completion flag at the end. Both memories return data on the cycle after a read request. The map base and the character base are taken from two byte-wide setting inputs at the moment a frame is accepted. A select input chooses which half of the shared character setting applies.

Top module: `tile_bg_render`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done`, `pix_valid`, `vram_rd` and `pal_rd` are low. Reset taken at any point aborts a frame. The first pixel of a frame carries x=0, y=0.
- R2: `start` is accepted only while `busy` is low. The base settings are captured on the accepting edge. A `start` pulse or a change of `map_reg`, `chr_reg` or `chr_sel` while `busy` is high has no effect on the frame.
- R3: The map base byte address is `map_reg[6:2]` placed at address bits 15:11 (bits 7, 1 and 0 are ignored). The entry of tile row r, column c sits at base + (r*32 + c)*2. All address sums wrap modulo 65536.
- R4: The character base is `chr_reg[3:0]` shifted left by 12 when `chr_sel` is 0, and `chr_reg[7:4]` shifted left by 12 when `chr_sel` is 1.
- R5: In a map entry, the byte at the even address gives tile number bits 7:0. The next byte gives tile number bits 9:8 in its bits 1:0 and the palette number in its bits 4:2.
- R6: A tile spans 16 bytes. For pixel line i, plane 0 is read at charbase + tile*16 + 2*i and plane 1 at the next byte. Pixel j of the line takes bit 7-j of each plane byte. Plane 0 supplies colour bit 0 and plane 1 supplies colour bit 1.
- R7: For each pixel the block reads `pal_addr` = 2*(palette*4 + colour). `pix_color` shows the `pal_data` word returned for that read (low byte from `pal_addr`, bits 14:8 from the next byte).
- R8: A frame yields exactly 57344 pixels with no gaps, x running 0..255 within each line and y running 0..223.
- R9: Both memories return data on the cycle after a read request. The first valid pixel appears after the 9th rising edge that follows the edge accepting `start`.
- R10: `done` is a one-cycle pulse in the cycle right after the last pixel. `busy` is low from that cycle on.
- R11: `vram_rd` and `pal_rd` are asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse |
| map_reg | input | 8 | Map base setting |
| chr_reg | input | 8 | Shared character base setting (two nibbles) |
| chr_sel | input | 1 | Selects the nibble of `chr_reg` in use |
| vram_rd | output | 1 | Video memory read request |
| vram_addr | output | 16 | Video memory byte address |
| vram_data | input | 8 | Video memory read data, one cycle after request |
| pal_rd | output | 1 | Palette read request |
| pal_addr | output | 9 | Palette byte address (even) |
| pal_data | input | 15 | Colour word, one cycle after request |
| pix_valid | output | 1 | Pixel output valid |
| pix_x | output | 8 | Pixel column |
| pix_y | output | 8 | Pixel line |
| pix_color | output | 15 | Pixel colour |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |

## Verification
The embedded properties follow the output coordinate stream on every cycle. They check that x steps by one and y advances only at a line wrap. They check that the first pixel is at the origin, that `done` is a single pulse following pixel (255,223), that no memory read occurs outside a frame, and that the captured bases stay constant while a frame is running. The decoding of the map entries and plane bytes, the base-address scaling and wrap, the palette indexing and the exact pipeline latency only show in the colour values and cycle counts. The bench's scenarios compare these against a model built from the requirements, across two base and content configurations, with a start pulse during a frame and a reset in mid-frame.

// File: rtl/tile_bg_render.sv
module tile_bg_render (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  map_reg,
  input  logic [7:0]  chr_reg,
  input  logic        chr_sel,
  output logic        vram_rd,
  output logic [15:0] vram_addr,
  input  logic [7:0]  vram_data,
  output logic        pal_rd,
  output logic [8:0]  pal_addr,
  input  logic [14:0] pal_data,
  output logic        pix_valid,
  output logic [7:0]  pix_x,
  output logic [7:0]  pix_y,
  output logic [14:0] pix_color,
  output logic        busy,
  output logic        done
);
  localparam logic [4:0] LAST_COL  = 5'd31;
  localparam logic [7:0] LAST_LINE = 8'd223;
  localparam logic [2:0] LAST_SLOT = 3'd7;

  logic        run, fetch_on, act_vld, r_last;
  logic [2:0]  slot;
  logic [4:0]  fcol, ocol;
  logic [7:0]  fline, oline;
  logic [15:0] tbase, cbase;
  logic [7:0]  lo_r, sp0, sp1, ap0, ap1;
  logic [9:0]  idx_r;
  logic [2:0]  pal_r, apal;

  wire [15:0] entry_a  = tbase + {5'b0, fline[7:3], fcol, 1'b0};
  wire [9:0]  idx_now  = (slot == 3'd2) ? {vram_data[1:0], lo_r} : idx_r;
  wire [15:0] row_a    = cbase + {2'b0, idx_now, 4'b0} + {12'b0, fline[2:0], 1'b0};
  wire        last_tile = (fcol == LAST_COL) && (fline == LAST_LINE);
  wire [2:0]  bsel     = ~slot;
  wire [1:0]  cidx     = {ap1[bsel], ap0[bsel]};

  assign vram_rd = run && fetch_on && !slot[2];
  always_comb begin
    case (slot)
      3'd0:    vram_addr = entry_a;
      3'd1:    vram_addr = entry_a + 16'd1;
      3'd2:    vram_addr = row_a;
      default: vram_addr = row_a + 16'd1;
    endcase
  end

  assign pal_rd    = act_vld;
  assign pal_addr  = {3'b0, apal, cidx, 1'b0};
  assign pix_color = pix_valid ? pal_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; fetch_on <= 1'b0; act_vld <= 1'b0; r_last <= 1'b0;
      busy <= 1'b0; done <= 1'b0; pix_valid <= 1'b0;
      pix_x <= '0; pix_y <= '0; slot <= '0;
      fcol <= '0; fline <= '0; ocol <= '0; oline <= '0;
      tbase <= '0; cbase <= '0;
      lo_r <= '0; sp0 <= '0; sp1 <= '0; ap0 <= '0; ap1 <= '0;
      idx_r <= '0; pal_r <= '0; apal <= '0;
    end else begin
      done      <= r_last;
      r_last    <= act_vld && (slot == LAST_SLOT) && !fetch_on;
      pix_valid <= act_vld;
      pix_x     <= {ocol, slot};
      pix_y     <= oline;
      if (r_last) busy <= 1'b0;
      if (!busy && start) begin
        busy     <= 1'b1;
        run      <= 1'b1;
        fetch_on <= 1'b1;
        act_vld  <= 1'b0;
        slot     <= '0;
        fcol     <= '0;
        fline    <= '0;
        tbase    <= {map_reg[6:2], 11'b0};
        cbase    <= {(chr_sel ? chr_reg[7:4] : chr_reg[3:0]), 12'b0};
      end else if (run) begin
        slot <= slot + 3'd1;
        case (slot)
          3'd1: lo_r <= vram_data;
          3'd2: begin
            idx_r <= {vram_data[1:0], lo_r};
            pal_r <= vram_data[4:2];
          end
          3'd3: sp0 <= vram_data;
          3'd4: sp1 <= vram_data;
          default: ;
        endcase
        if (slot == LAST_SLOT) begin
          if (fetch_on) begin
            ap0     <= sp0;
            ap1     <= sp1;
            apal    <= pal_r;
            act_vld <= 1'b1;
            ocol    <= fcol;
            oline   <= fline;
            if (last_tile) begin
              fetch_on <= 1'b0;
            end else if (fcol == LAST_COL) begin
              fcol  <= '0;
              fline <= fline + 8'd1;
            end else begin
              fcol <= fcol + 5'd1;
            end
          end else begin
            act_vld <= 1'b0;
            run     <= 1'b0;
          end
        end
      end
    end
  end

  // R8
  raster_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && pix_x != 8'd0) |-> pix_x == $past(pix_x) + 8'd1);
  // R8
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && pix_x == 8'd0) |-> pix_y == $past(pix_y) + 8'd1);
  // R1
  origin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (pix_x == 8'd0 && pix_y == 8'd0));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pix_valid) && $past(pix_x) == 8'd255 && $past(pix_y) == 8'd223 && !busy));
  // R11
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_rd || pal_rd) |-> busy);
  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(tbase) && $stable(cbase)));
endmodule

// File: tb/tile_bg_render_bench.sv
`timescale 1ns/1ps
module tile_bg_render_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  map_reg = '0;
  logic [7:0]  chr_reg = '0;
  logic        chr_sel = 1'b0;
  logic        vram_rd, pal_rd, pix_valid, busy, done;
  logic [15:0] vram_addr;
  logic [7:0]  vram_data = '0;
  logic [8:0]  pal_addr;
  logic [14:0] pal_data = '0;
  logic [7:0]  pix_x, pix_y;
  logic [14:0] pix_color;
  logic [7:0]  salt = '0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  tile_bg_render u_tile_bg_render (
    .clk(clk), .rst_n(rst_n), .start(start), .map_reg(map_reg), .chr_reg(chr_reg),
    .chr_sel(chr_sel), .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_data(vram_data),
    .pal_rd(pal_rd), .pal_addr(pal_addr), .pal_data(pal_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color), .busy(busy), .done(done));

  function automatic logic [7:0] vb(input logic [15:0] a, input logic [7:0] s);
    logic [15:0] m;
    m = a * 16'd37;
    return m[10:3] ^ a[15:8] ^ s;
  endfunction

  function automatic logic [7:0] pb(input logic [8:0] a, input logic [7:0] s);
    logic [15:0] m;
    m = {7'b0, a} * 16'd53 + {8'b0, s};
    return m[7:0] ^ m[12:5];
  endfunction

  function automatic logic [14:0] pw(input logic [8:0] a, input logic [7:0] s);
    logic [7:0] l, h;
    l = pb(a, s);
    h = pb(a + 9'd1, s);
    return {h[6:0], l};
  endfunction

  always @(posedge clk) begin
    if (vram_rd) vram_data <= vb(vram_addr, salt);
    if (pal_rd)  pal_data  <= pw(pal_addr, salt);
  end

  function automatic logic [14:0] exp_col(input logic [7:0] x, input logic [7:0] y,
                                          input logic [15:0] tb, input logic [15:0] cb,
                                          input logic [7:0] s);
    logic [15:0] ea, ta;
    logic [7:0]  lo, hi, p0, p1;
    logic [9:0]  idx;
    logic [2:0]  pl, j;
    logic [1:0]  c;
    logic [4:0]  pi;
    ea  = tb + ({11'b0, y[7:3]} * 16'd32 + {11'b0, x[7:3]}) * 16'd2;
    lo  = vb(ea, s);
    hi  = vb(ea + 16'd1, s);
    idx = {hi[1:0], lo};
    pl  = hi[4:2];
    ta  = cb + {6'b0, idx} * 16'd16 + {13'b0, y[2:0]} * 16'd2;
    p0  = vb(ta, s);
    p1  = vb(ta + 16'd1, s);
    j   = 3'd7 - x[2:0];
    c   = {p1[j], p0[j]};
    pi  = {pl, 2'b00} + {3'b0, c};
    return pw({3'b0, pi, 1'b0}, s);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // map_reg, chr_reg, chr_sel, salt
  localparam int NVEC = 2;
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h7D, 8'h5F, 1'b0, 8'h00},
    {8'h86, 8'h3A, 1'b1, 8'hA5}
  };

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", busy, 0);
    check("R1 outputs quiet in reset", {done, pix_valid, vram_rd, pal_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busy, done, pix_valid, vram_rd, pal_rd}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] tb, cb;
      int lat, cnt, bad, posbad;
      logic [7:0] ex, ey;
      logic [14:0] ec;
      map_reg = VEC[v][24:17];
      chr_reg = VEC[v][16:9];
      chr_sel = VEC[v][8];
      salt    = VEC[v][7:0];
      tb = {map_reg[6:2], 11'b0};                                    // R3
      cb = chr_sel ? {chr_reg[7:4], 12'b0} : {chr_reg[3:0], 12'b0};  // R4
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", busy, 1);
      lat = 0;
      do begin
        @(posedge clk); lat++; @(negedge clk);
      end while (!pix_valid && lat < 50);
      check("R9 first pixel latency", lat, 9);
      cnt = 0; bad = 0; posbad = 0; ex = 0; ey = 0;
      while (pix_valid && cnt < 60000) begin
        ec = exp_col(ex, ey, tb, cb, salt);
        if (pix_x != ex || pix_y != ey) posbad++;
        if (pix_color != ec) begin
          if (bad == 0)
            $display("  first colour mismatch at x=%0d y=%0d got=%h want=%h", ex, ey, pix_color, ec);
          bad++;
        end
        cnt++;
        ex = ex + 8'd1;
        if (ex == 8'd0) ey = ey + 8'd1;
        start = (cnt == 1000);
        if (cnt == 1000) begin
          map_reg = ~map_reg;
          chr_reg = ~chr_reg;
          chr_sel = ~chr_sel;
        end
        @(posedge clk); @(negedge clk);
      end
      start = 1'b0;
      check("R8 pixel count without gaps", cnt, 57344);
      check("R8 raster coordinates", posbad, 0);
      check("R3 R4 R5 R6 R7 R2 colour stream", bad, 0);
      check("R10 done after last pixel", done, 1);
      check("R10 busy low at done", busy, 0);
      @(negedge clk);
      check("R10 done single cycle", done, 0);
      check("R11 no reads after frame", {vram_rd, pal_rd}, 0);
    end

    // R1 reset aborts a running frame, R9 latency after restart
    begin
      int lat;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 reset aborts frame", {busy, done, pix_valid, vram_rd, pal_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after abort", busy, 0);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      lat = 0;
      do begin
        @(posedge clk); lat++; @(negedge clk);
      end while (!pix_valid && lat < 50);
      check("R9 latency after abort", lat, 9);
      check("R1 first pixel origin", {pix_x, pix_y}, 0);
    end

    summary();
    $finish;
  end
endmodule